// File: doc/BRIEF.md
# Byte-Lane Data Parity Unit

This block sits beside a 32-bit data bus that is divided into four 8-bit lanes. On the write side it computes one even-parity bit per lane from the outgoing data. The parity bits are combinational, so they change in the same cycle as the write data and follow whatever timing the bus master uses to drive that data.

On the read side it compares each lane's returned parity bit with the sampled data. It does this only in a cycle where the read-ready input is high. A lane counts as failing when its eight data bits plus its parity bit hold an odd number of ones. Only lanes that are both enabled and inside the current bus width take part. Any failing lane drives an active-low error flag low for exactly one clock, in the clock after the ready cycle. In every other clock the flag is high.

The block only reports. It never alters the data path and takes no part in the bus handshake.

Top module: `lane_parity_unit`

## Requirements
- R1: `wr_par[i]` is the even-parity bit of `wr_data[8*i+7:8*i]`. Lane 0 covers bits 7:0 and lane 3 covers bits 31:24. The data byte and its parity bit together always hold an even number of ones.
- R2: `wr_par` is combinational from `wr_data`. It is valid in the same cycle as the write data, with no register in between.
- R3: If `rd_ready` is high at a rising edge and any eligible lane holds an odd number of ones over its data byte and `rd_par` bit, `perr_n` is low during the following clock.
- R4: `perr_n` is high in every clock that does not follow a cycle in which `rd_ready` was sampled high. The low state therefore lasts one clock per ready cycle.
- R5: A lane whose active-low enable `be_n[i]` is high is never checked. A fault on that lane leaves `perr_n` high.
- R6: With `size16_n` low and `size8_n` high, only lanes 0 and 1 are eligible. Faults on lanes 2 and 3 are ignored.
- R7: With `size8_n` low, only lane 0 is eligible, whatever the value of `size16_n`.
- R8: A synchronous active-high `rst` forces `perr_n` high at the next edge. This overrides a read that is being checked in the same cycle.
- R9: With both size inputs high, all four lanes are eligible, subject to their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 32 | Outgoing write data |
| wr_par | output | 4 | Even parity per lane for `wr_data` |
| rd_data | input | 32 | Read data sampled from the bus |
| rd_par | input | 4 | Lane parity returned with the read data |
| be_n | input | 4 | Byte enables, active low |
| size8_n | input | 1 | 8-bit bus width select, active low |
| size16_n | input | 1 | 16-bit bus width select, active low |
| rd_ready | input | 1 | High in the cycle a read completes |
| perr_n | output | 1 | Read parity error, active low, one clock after ready |

## Verification
Two of the block's functions can land in the same edge: a faulty read being checked, and the synchronous reset.

The bench provokes this by raising `rst` in the very cycle that `rd_ready` presents a corrupted lane 0. It then expects `perr_n` to stay high in the following clock. It also provokes back-to-back ready cycles, one clean and one faulty, so that an error pulse from one read must not spill into the clock that belongs to the next. Each result is judged against a per-read expected flag that is computed from the lane eligibility rules.

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic [LANES-1:0]          wr_par,
  input  logic [LANES*LANE_W-1:0]   rd_data,
  input  logic [LANES-1:0]          rd_par,
  input  logic [LANES-1:0]          be_n,
  input  logic                      size8_n,
  input  logic                      size16_n,
  input  logic                      rd_ready,
  output logic                      perr_n
);

  localparam int TOP = LANES - 1;

  logic [LANES-1:0] odd;
  logic [LANES-1:0] in_width;
  logic             hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_par[g]   = ^wr_data[g*LANE_W +: LANE_W];
    assign odd[g]      = ^{rd_data[g*LANE_W +: LANE_W], rd_par[g]};
    assign in_width[g] = !size8_n  ? (g < 1) :
                         !size16_n ? (g < 2) : 1'b1;

    always_comb begin
      if (!$isunknown(wr_data))
        assert_write_even_R1: assert ((^{wr_data[g*LANE_W +: LANE_W], wr_par[g]}) == 1'b0);
    end
  end

  assign hit = |(odd & ~be_n & in_width);

  always_ff @(posedge clk) begin
    if (rst) perr_n <= 1'b1;
    else     perr_n <= ~(rd_ready & hit);
  end

  assert_reset_high_R8: assert property (@(posedge clk) rst |=> perr_n);

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_ready |=> perr_n);

  assert_be_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && (&be_n)) |=> perr_n);

  assert_bs8_only_lane0_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !size8_n && ((^{rd_data[LANE_W-1:0], rd_par[0]}) == 1'b0)) |=> perr_n);

  assert_bs16_two_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && size8_n && !size16_n
     && ((^{rd_data[LANE_W-1:0], rd_par[0]}) == 1'b0)
     && ((^{rd_data[2*LANE_W-1:LANE_W], rd_par[1]}) == 1'b0)) |=> perr_n);

  assert_full_width_top_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && size8_n && size16_n && !be_n[TOP]
     && ((^{rd_data[TOP*LANE_W +: LANE_W], rd_par[TOP]}) == 1'b1)) |=> !perr_n);

endmodule

// File: tb/test_lane_parity_unit.sv
module test_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_par;
  logic [31:0] rd_data = '0;
  logic [3:0]  rd_par = '0;
  logic [3:0]  be_n = 4'hF;
  logic        size8_n = 1'b1;
  logic        size16_n = 1'b1;
  logic        rd_ready = 1'b0;
  logic        perr_n;

  int   n_checks = 0;
  int   n_fail   = 0;
  logic due = 1'b0;
  logic run = 1'b0;
  logic exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  lane_parity_unit i_lane_parity_unit (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_par(wr_par),
    .rd_data(rd_data), .rd_par(rd_par), .be_n(be_n),
    .size8_n(size8_n), .size16_n(size16_n), .rd_ready(rd_ready), .perr_n(perr_n)
  );

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic exp_flag(input logic [31:0] d, input logic [3:0] p,
                                    input logic [3:0] be, input logic s8, input logic s16);
    for (int i = 0; i < 4; i++) begin
      logic elig;
      elig = !be[i] && (!s8 ? (i == 0) : (!s16 ? (i < 2) : 1'b1));
      if (elig && (^{d[i*8 +: 8], p[i]})) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [31:0] d, input int flip_lane,
                         input logic [3:0] be, input logic s8, input logic s16);
    logic [3:0] p;
    p = good_par(d);
    if (flip_lane >= 0) d[flip_lane*8 + (flip_lane % 8)] = ~d[flip_lane*8 + (flip_lane % 8)];
    @(negedge clk);
    rd_data = d; rd_par = p; be_n = be; size8_n = s8; size16_n = s16; rd_ready = 1'b1;
    exp_q.push_back(exp_flag(d, p, be, s8, s16));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_ready = 1'b0;
    end
  endtask

  always @(posedge clk) due <= rd_ready & !rst;

  always @(negedge clk) begin
    if (run) begin
      if (due) begin
        if (exp_q.size() == 0) check("R4 queue", perr_n, 1'b1);
        else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, perr_n, e);
        end
      end else begin
        check("R4 idle", perr_n, 1'b1);
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", perr_n, 1'b1);
    rst = 1'b0;
    run = 1'b1;

    wr_data = 32'h0000_0000; #1 check("R1 zero", wr_par == 4'b0000, 1'b1);
    wr_data = 32'h0102_0408; #1 check("R1 one bit per lane", wr_par == 4'b1111, 1'b1);
    wr_data = 32'h8000_00FF; #1 check("R1 lane3 msb", wr_par == 4'b1000, 1'b1);
    wr_data = 32'h0000_0300; #1 check("R2 lane1 same cycle", wr_par == 4'b0000, 1'b1);
    wr_data = 32'h0000_0700; #1 check("R2 lane1 same cycle", wr_par == 4'b0010, 1'b1);

    do_read("R9 clean full", 32'hDEAD_BEEF, -1, 4'h0, 1'b1, 1'b1);
    for (int l = 0; l < 4; l++) do_read("R3 fault per lane", 32'h1234_5678, l, 4'h0, 1'b1, 1'b1);
    idle(2);
    for (int l = 0; l < 4; l++)
      do_read("R5 disabled lane", 32'hA5A5_5A5A, l, 4'(1 << l), 1'b1, 1'b1);
    idle(1);
    do_read("R6 lane2 outside 16", 32'hCAFE_0001, 2, 4'h0, 1'b1, 1'b0);
    do_read("R6 lane3 outside 16", 32'hCAFE_0001, 3, 4'h0, 1'b1, 1'b0);
    do_read("R6 lane1 inside 16", 32'hCAFE_0001, 1, 4'h0, 1'b1, 1'b0);
    idle(1);
    do_read("R7 lane1 outside 8", 32'h0F0F_0F0F, 1, 4'h0, 1'b0, 1'b1);
    do_read("R7 both sizes lane1", 32'h0F0F_0F0F, 1, 4'h0, 1'b0, 1'b0);
    do_read("R7 lane0 inside 8", 32'h0F0F_0F0F, 0, 4'h0, 1'b0, 1'b0);
    do_read("R5 lane0 disabled at 8", 32'h0F0F_0F0F, 0, 4'h1, 1'b0, 1'b1);
    idle(1);
    do_read("R4 clean after clean", 32'h0000_0000, -1, 4'h0, 1'b1, 1'b1);
    do_read("R4 fault after clean", 32'h0000_0000, 0, 4'h0, 1'b1, 1'b1);
    do_read("R4 clean after fault", 32'h0000_0000, -1, 4'h0, 1'b1, 1'b1);
    idle(3);

    @(negedge clk);
    rd_data = 32'h0000_0001; rd_par = 4'b0000; be_n = 4'h0;
    size8_n = 1'b1; size16_n = 1'b1; rd_ready = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R8 reset beats fault", perr_n, 1'b1);
    rd_ready = 1'b0; rst = 1'b0;
    idle(3);

    run = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule